// File: doc/BRIEF.md
# Boot Vector Fetch Sequencer

This block starts a processor core after reset. Once reset has been released, it reads two 32-bit words from the bottom of the address space through a simple word read port. The first word becomes the initial stack pointer. The second word becomes the initial program counter. It then gives the core the stack pointer, an even program counter and a one-bit instruction-set state, and follows them with a single start pulse.

The read port works like this. The block raises `mem_req` and holds `mem_addr` steady until the memory answers with `mem_rvalid`, which carries `mem_rdata`. The answer may arrive in the same cycle as the request or any number of cycles later. The external reset is asynchronous and active-low. It takes effect at once and is released through a synchronizer. Asserting it at any moment abandons the sequence, which then starts again from the first read.

Top module: `boot_vector_fetch`

## Requirements
- R1: While reset is asserted, `mem_req` and `core_start` are 0, and `core_sp`, `core_pc` and `core_isa` are 0. After release, the first request made is to byte address 0.
- R2: The word returned for byte address 0 appears unchanged on `core_sp`. Words are little-endian: `mem_rdata[7:0]` is the byte at the lowest address of the word.
- R3: The second request is to byte address 4. It is issued only after the first read has been answered, so exactly two reads take place, in the order 0 then 4.
- R4: `core_pc` equals the word returned for address 4 with bit 0 forced to 0.
- R5: `core_isa` equals bit 0 of the word returned for address 4.
- R6: `core_start` is high for exactly one cycle per sequence. It rises only after both words have been captured, and the values on `core_sp`, `core_pc` and `core_isa` are already final when it does.
- R7: While a request is waiting for `mem_rvalid`, `mem_req` stays high and `mem_addr` stays constant. A `mem_rvalid` that arrives with no request outstanding has no effect on any output.
- R8: Asserting reset during either read drops `mem_req` at once. After release, the sequence starts again with a read of address 0.
- R9: After the start pulse, no further request is made until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Read request, held until answered |
| mem_addr | output | ADDR_W (32) | Byte address of the requested word |
| mem_rdata | input | DATA_W (32) | Returned word, little-endian |
| mem_rvalid | input | 1 | `mem_rdata` is valid for the outstanding request |
| core_sp | output | DATA_W (32) | Initial stack pointer |
| core_pc | output | DATA_W (32) | Initial program counter, bit 0 cleared |
| core_isa | output | 1 | Instruction-set state taken from bit 0 of the PC word |
| core_start | output | 1 | One-cycle start pulse for the core |

## Verification
The assertions check on every cycle the following:
- a pending request holds its address;
- the start pulse lasts a single cycle and is preceded by a read response;
- no request follows the start pulse;
- each capture loads the word, the cleared bit and the state bit from the response it follows.

Only the bench's scenarios can show the following:
- the read order and count over a whole sequence;
- that responses with nothing outstanding are ignored;
- that a reset in the middle of the first or second read restarts cleanly from address 0.

The bench covers these under several response latencies and with both odd and even program counter words.

// File: rtl/boot_fetch_pkg.sv
package boot_fetch_pkg;

  typedef enum logic [2:0] {
    BF_IDLE  = 3'd0,
    BF_SP    = 3'd1,
    BF_PC    = 3'd2,
    BF_START = 3'd3,
    BF_DONE  = 3'd4
  } bf_state_e;

endpackage

// File: rtl/bf_rst_sync.sv
module bf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign sync_d[i] = 1'b1;
      end else begin : g_next
        assign sync_d[i] = sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bf_fetch_ctrl.sv
module bf_fetch_ctrl
  import boot_fetch_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rvalid,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              cap_sp,
  output logic              cap_pc,
  output logic              start
);

  localparam logic [ADDR_W-1:0] SP_ADDR = '0;
  localparam logic [ADDR_W-1:0] PC_ADDR = ADDR_W'(WORD_BYTES);

  bf_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      BF_IDLE:  state_d = BF_SP;
      BF_SP:    if (rvalid) state_d = BF_PC;
      BF_PC:    if (rvalid) state_d = BF_START;
      BF_START: state_d = BF_DONE;
      BF_DONE:  state_d = BF_DONE;
      default:  state_d = BF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= BF_IDLE;
    else        state_q <= state_d;
  end

  assign mem_req  = (state_q == BF_SP) || (state_q == BF_PC);
  assign mem_addr = (state_q == BF_PC) ? PC_ADDR : SP_ADDR;
  assign cap_sp   = (state_q == BF_SP) && rvalid;
  assign cap_pc   = (state_q == BF_PC) && rvalid;
  assign start    = (state_q == BF_START);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !rvalid) |=> (mem_req && $stable(mem_addr))) else $error("req hold"); // R7

  AST_PC_AFTER_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_addr == PC_ADDR) |-> $past(mem_req)) else $error("pc order"); // R3

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start) else $error("start width"); // R6

  AST_NO_REQ_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !mem_req) else $error("req after start"); // R9

endmodule

// File: rtl/bf_vec_regs.sv
module bf_vec_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_sp,
  input  logic              cap_pc,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] sp,
  output logic [DATA_W-1:0] pc,
  output logic              isa
);

  logic [DATA_W-1:0] sp_q, sp_d, pc_q, pc_d;
  logic              isa_q, isa_d;

  always_comb begin
    sp_d  = sp_q;
    pc_d  = pc_q;
    isa_d = isa_q;
    if (cap_sp) sp_d = rdata;
    if (cap_pc) begin
      pc_d  = {rdata[DATA_W-1:1], 1'b0};
      isa_d = rdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      pc_q  <= '0;
      isa_q <= 1'b0;
    end else begin
      sp_q  <= sp_d;
      pc_q  <= pc_d;
      isa_q <= isa_d;
    end
  end

  assign sp  = sp_q;
  assign pc  = pc_q;
  assign isa = isa_q;

  AST_SP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_sp |=> (sp == $past(rdata))) else $error("sp capture"); // R2

  AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pc |=> (pc[DATA_W-1:1] == $past(rdata[DATA_W-1:1]) && !pc[0])) else $error("pc capture"); // R4

  AST_ISA_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pc |=> (isa == $past(rdata[0]))) else $error("isa capture"); // R5

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_sp && !cap_pc) |=> ($stable(sp) && $stable(pc) && $stable(isa))) else $error("hold"); // R7

endmodule

// File: rtl/boot_vector_fetch.sv
module boot_vector_fetch #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rvalid,
  output logic [DATA_W-1:0] core_sp,
  output logic [DATA_W-1:0] core_pc,
  output logic              core_isa,
  output logic              core_start
);

  localparam int WORD_BYTES = DATA_W / 8;

  logic rst_int_n;
  logic cap_sp, cap_pc;

  bf_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_int_n)
  );

  bf_fetch_ctrl #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rvalid   (mem_rvalid),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .cap_sp   (cap_sp),
    .cap_pc   (cap_pc),
    .start    (core_start)
  );

  bf_vec_regs #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cap_sp (cap_sp),
    .cap_pc (cap_pc),
    .rdata  (mem_rdata),
    .sp     (core_sp),
    .pc     (core_pc),
    .isa    (core_isa)
  );

  AST_START_AFTER_RESPONSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(core_start) |-> $past(mem_rvalid)) else $error("start without response"); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!mem_req && !core_start)) else $error("reset quiet"); // R1

endmodule

// File: tb/boot_vector_fetch_tb.sv
module boot_vector_fetch_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] core_sp, core_pc;
  logic        core_isa, core_start;

  always #2.5 clk = ~clk;

  boot_vector_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .core_sp(core_sp),
    .core_pc(core_pc), .core_isa(core_isa), .core_start(core_start)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] word_sp, word_pc;
  int          lat = 0;
  int          wait_cnt = 0;
  logic        spur = 1'b0;
  int          rd_cnt = 0;
  logic [31:0] rd_log [4];
  int          start_cnt = 0;
  int          hold_viol = 0;
  logic        hold_pend = 1'b0;
  logic [31:0] hold_addr = '0;

  // memory model and monitors, all at the falling edge
  always @(negedge clk) begin
    if (core_start) start_cnt++;
    if (!rst_n) begin
      hold_pend = 1'b0;
      wait_cnt  = 0;
      mem_rvalid <= spur;
      mem_rdata  <= 32'hBAD0_0BAD;
    end else begin
      if (hold_pend && !(mem_req && mem_addr == hold_addr)) hold_viol++;
      hold_pend = 1'b0;
      if (spur) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= 32'hBAD0_0BAD;
      end else if (mem_rvalid) begin
        mem_rvalid <= 1'b0;
        wait_cnt = 0;
        if (mem_req) begin
          hold_pend = 1'b1;
          hold_addr = mem_addr;
        end
      end else if (mem_req) begin
        if (wait_cnt >= lat) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= (mem_addr == 32'd0) ? word_sp :
                        (mem_addr == 32'd4) ? word_pc : 32'hDEAD_BEEF;
          if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr;
          rd_cnt++;
          wait_cnt = 0;
        end else begin
          wait_cnt++;
          hold_pend = 1'b1;
          hold_addr = mem_addr;
        end
      end else begin
        wait_cnt = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_logs();
    rd_cnt = 0;
    start_cnt = 0;
    hold_viol = 0;
  endtask

  task automatic wait_start();
    for (int i = 0; i < 200 && start_cnt == 0; i++) @(negedge clk);
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wait_cycles(3);
  endtask

  // full sequence with given words and latency
  task automatic t_boot(input logic [31:0] sp_w, input logic [31:0] pc_w, input int l);
    word_sp = sp_w; word_pc = pc_w; lat = l;
    enter_reset();
    check(mem_req == 1'b0 && core_start == 1'b0, "R1", "quiet in reset",
          {30'd0, mem_req, core_start}, 32'd0);
    check(core_sp == 0 && core_pc == 0 && core_isa == 0, "R1", "outputs cleared in reset",
          core_sp | core_pc, 32'd0);
    clear_logs();
    rst_n = 1'b1;
    wait_start();
    wait_cycles(4);
    check(rd_cnt == 2, "R3", "read count", rd_cnt, 2);
    check(rd_log[0] == 32'd0, "R1", "first read address", rd_log[0], 32'd0);
    check(rd_log[1] == 32'd4, "R3", "second read address", rd_log[1], 32'd4);
    check(core_sp == sp_w, "R2", "stack pointer", core_sp, sp_w);
    check(core_pc == {pc_w[31:1], 1'b0}, "R4", "program counter", core_pc, {pc_w[31:1], 1'b0});
    check(core_isa == pc_w[0], "R5", "isa state", {31'd0, core_isa}, {31'd0, pc_w[0]});
    check(start_cnt == 1, "R6", "start pulse cycles", start_cnt, 1);
    check(hold_viol == 0, "R7", "request held while waiting", hold_viol, 0);
    check(mem_req == 1'b0, "R9", "no request after start", {31'd0, mem_req}, 32'd0);
  endtask

  // start pulse sees final values
  task automatic t_start_values();
    logic [31:0] sp_at, pc_at;
    word_sp = 32'h2000_1000; word_pc = 32'h0000_0201; lat = 2;
    enter_reset();
    clear_logs();
    rst_n = 1'b1;
    sp_at = '0; pc_at = '0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (core_start) begin sp_at = core_sp; pc_at = core_pc; break; end
    end
    check(sp_at == 32'h2000_1000, "R6", "sp final at start", sp_at, 32'h2000_1000);
    check(pc_at == 32'h0000_0200, "R6", "pc final at start", pc_at, 32'h0000_0200);
  endtask

  // responses with nothing outstanding are ignored
  task automatic t_spurious();
    logic [31:0] sp0, pc0;
    logic        isa0;
    t_boot(32'h1111_2222, 32'h3333_4445, 1);
    sp0 = core_sp; pc0 = core_pc; isa0 = core_isa;
    spur = 1'b1;
    wait_cycles(6);
    spur = 1'b0;
    wait_cycles(2);
    check(core_sp == sp0 && core_pc == pc0 && core_isa == isa0, "R7", "stray response ignored",
          core_sp ^ sp0 ^ core_pc ^ pc0, 32'd0);
    check(start_cnt == 1 && mem_req == 1'b0, "R9", "no restart after stray response",
          start_cnt, 1);
  endtask

  // reset during a pending read
  task automatic t_abort(input logic [31:0] at_addr, input string tag);
    word_sp = 32'hAAAA_0000; word_pc = 32'h5555_0003; lat = 6;
    enter_reset();
    clear_logs();
    rst_n = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (mem_req && mem_addr == at_addr) break;
    end
    wait_cycles(2);
    rst_n = 1'b0;
    #1;
    check(mem_req == 1'b0, "R8", {tag, " request dropped at reset"}, {31'd0, mem_req}, 32'd0);
    check(start_cnt == 0, "R8", {tag, " no start before abort"}, start_cnt, 0);
    wait_cycles(2);
    word_sp = 32'h1234_5678; word_pc = 32'h0800_00C0; lat = 0;
    clear_logs();
    @(negedge clk);
    rst_n = 1'b1;
    wait_start();
    wait_cycles(3);
    check(rd_cnt == 2 && rd_log[0] == 32'd0, "R8", {tag, " restart from address 0"},
          rd_log[0], 32'd0);
    check(core_sp == 32'h1234_5678 && core_pc == 32'h0800_00C0 && core_isa == 1'b0,
          "R8", {tag, " values after restart"}, core_pc, 32'h0800_00C0);
    check(start_cnt == 1, "R6", {tag, " single start after restart"}, start_cnt, 1);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    word_sp = '0; word_pc = '0;
    t_boot(32'h2000_8000, 32'h0000_0101, 0);
    t_boot(32'h2000_4000, 32'h0000_0400, 3);
    t_boot(32'hFFFF_FFFC, 32'hFFFF_FFFF, 7);
    t_boot(32'h0403_0201, 32'h0807_0605, 1);
    t_start_values();
    t_spurious();
    t_abort(32'd0, "sp read");
    t_abort(32'd4, "pc read");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule